// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Control Words

This block controls 32 general-purpose pins through a small register-mapped bus. The bus has an address, a write word, a write strobe and a combinational read word. The pins are split into two banks of 16. Pins 0 to 15 form the low bank, at base address 0x00. Pins 16 to 31 form the high bank, whose window starts 0x80 above the low bank.

Each bank holds six per-pin control registers and one read-only view of the pin inputs. Every control write carries a 32-bit word that sets some pin bits and clears others in the same access. Software therefore never has to read a register, merge its change and write it back. This removes the race between two agents that update different pins of the same register.

The pad side is modelled as three separate vectors: input level, output level and output enable. Pad inputs go through a two-flop synchronizer before software can read them. Four pins are permanently unusable and stay inert whatever is written to them.

Top module: `gpio_setclr_top`

## Requirements
- R1: Within each bank window the register offsets are: 0x00 output level, 0x04 drive enable, 0x08 input enable, 0x0C output alternate select A, 0x10 output alternate select B, 0x14 input alternate select, and 0x18 pin read-back. The high bank window is the low bank window plus 0x80 (address bit 7 selects the bank). Any other address reads as zero, and a write to it changes nothing.
- R2: In a control write, data bit n (n = 0..15) set to 1 sets pin n of the bank, and data bit n+16 set to 1 clears it. A 0 in either position leaves the pin unchanged. When both bits are 1, the set wins.
- R3: Every read returns the 16 bank bits in data bits 15:0 and zero in bits 31:16.
- R4: After reset, every control register reads zero, no pad is driven, and every read-back bit is zero.
- R5: Pins 23, 29, 30 and 31 are reserved. Their control bits read zero, ignore writes, never drive a pad and read back zero.
- R6: A pin drives its pad only when its drive enable is 1 and both output alternate selects are 0. While it drives, the output level equals its output level bit. The output level of an undriven pin is 0.
- R7: Read-back bit n shows the synchronized pad input for pin n only while that pin's input enable is 1; otherwise it reads 0. Writes to the read-back offset are ignored.
- R8: A write is visible on reads and pads from the clock edge that accepts it. A pad input change reaches the read-back value after the second rising edge that samples it.
- R9: The input alternate select is stored and read back, but affects neither the pads nor the read-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Set/clear control word (set in 15:0, clear in 31:16) |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read word for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous to clk |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables |

## Verification
A write takes effect at the rising edge that accepts it. Its effect on the pads and on the read word is therefore due one edge after the strobe. A pad input change has to pass two registers, so it is due in read-back only after the second edge. The bench drives its inputs on the falling edge. At every rising edge, a behavioural model takes in the same inputs, with a two-entry history of the pad inputs standing in for the synchronizer. On each falling edge the bench compares the pads and the read word against that model, so every result is checked in the first cycle it is due. Directed reads after a pad change confirm the two-edge latency directly: the bit is still zero after one edge and set after two.

// File: rtl/gpio_setclr_pkg.sv
// Shared definitions for the dual-bank set/clear GPIO controller.
// Assumes the register index is taken from byte-address bits 4:2.
package gpio_setclr_pkg;

    // Number of writable per-pin control registers in a bank.
    localparam int unsigned NREG_CTL = 6;

    // Register index inside a bank window; the value equals the word offset.
    typedef enum logic [2:0] {
        REG_OUTVAL = 3'd0,
        REG_OUTEN  = 3'd1,
        REG_INEN   = 3'd2,
        REG_OALT_A = 3'd3,
        REG_OALT_B = 3'd4,
        REG_IALT   = 3'd5,
        REG_RDBK   = 3'd6,
        REG_NONE   = 3'd7
    } gpio_reg_e;

endpackage

// File: rtl/gpio_bank_ctl.sv
// One bank of per-pin control registers updated by set/clear words.
// Assumes wr_en is already qualified by the bank decode. Reserved pins
// are held at zero. When a set and a clear hit the same pin, the set wins.
module gpio_bank_ctl
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned BW = 16,
    parameter logic [BW-1:0] RSVD = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  gpio_reg_e                    wr_sel,
    input  logic [2*BW-1:0]              wr_word,
    output logic [NREG_CTL-1:0][BW-1:0]  ctl_q
);

    logic [BW-1:0] set_bits;
    logic [BW-1:0] clr_bits;

    // Split the write word into its set half and its clear half.
    assign set_bits = wr_word[BW-1:0];
    assign clr_bits = wr_word[2*BW-1:BW];

    for (genvar r = 0; r < NREG_CTL; r++) begin : g_reg
        logic [BW-1:0] q;

        // Hold one control register; apply clear, then set, then the reserved mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_sel == gpio_reg_e'(r))) begin
                q <= ((q & ~clr_bits) | set_bits) & ~RSVD;
            end
        end

        assign ctl_q[r] = q;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous pad inputs.
// Assumes each bit is independent; there is no multi-bit coherence.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Pass the pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
// Output stage of one bank: a pin drives its pad only when drive enable is 1
// and neither output alternate select is 1. Purely combinational.
module gpio_pad_drive #(
    parameter int unsigned BW = 16
) (
    input  logic [BW-1:0] out_val,
    input  logic [BW-1:0] out_en,
    input  logic [BW-1:0] alt_a,
    input  logic [BW-1:0] alt_b,
    output logic [BW-1:0] pad_out,
    output logic [BW-1:0] pad_oe
);

    logic [BW-1:0] drive;

    // Decide per pin whether the controller owns the pad.
    always_comb begin
        drive   = out_en & ~alt_a & ~alt_b;
        pad_oe  = drive;
        pad_out = out_val & drive;
    end

endmodule

// File: rtl/gpio_setclr_top.sv
// Dual-bank GPIO controller. Address bit ADDR_W-1 selects the bank, bits 4:2
// select the register, and all other address bits must be zero. Reads are
// combinational. Writes take effect at the rising edge that accepts them.
module gpio_setclr_top
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [NPINS-1:0] RSVD_PINS = 32'hE080_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    localparam int unsigned BW      = NPINS / 2;
    localparam int unsigned NBANK   = 2;
    localparam int unsigned BANK_B  = ADDR_W - 1;
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_MSB = 4;

    logic                                     bank_sel;
    logic                                     addr_ok;
    gpio_reg_e                                reg_sel;
    logic [NBANK-1:0][NREG_CTL-1:0][BW-1:0]   ctl_st;
    logic [NPINS-1:0]                         sync_q;
    logic [NPINS-1:0]                         in_en_all;
    logic [NPINS-1:0]                         rdbk;
    logic [BW-1:0]                            rd_half;

    // Decode the bank and the register; an off-grid address selects nothing.
    always_comb begin
        bank_sel = bus_addr[BANK_B];
        addr_ok  = (bus_addr[BANK_B-1:IDX_MSB+1] == '0) && (bus_addr[IDX_LSB-1:0] == '0);
        reg_sel  = REG_NONE;
        if (addr_ok) begin
            reg_sel = gpio_reg_e'(bus_addr[IDX_MSB:IDX_LSB]);
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_bank_ctl #(
            .BW   (BW),
            .RSVD (RSVD_PINS[b*BW +: BW])
        ) u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && (bank_sel == 1'(b))),
            .wr_sel  (reg_sel),
            .wr_word (bus_wdata),
            .ctl_q   (ctl_st[b])
        );

        gpio_pad_drive #(
            .BW (BW)
        ) u_drv (
            .out_val (ctl_st[b][REG_OUTVAL]),
            .out_en  (ctl_st[b][REG_OUTEN]),
            .alt_a   (ctl_st[b][REG_OALT_A]),
            .alt_b   (ctl_st[b][REG_OALT_B]),
            .pad_out (pad_out[b*BW +: BW]),
            .pad_oe  (pad_oe[b*BW +: BW])
        );

        assign in_en_all[b*BW +: BW] = ctl_st[b][REG_INEN];
    end

    gpio_in_sync #(
        .W (NPINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    // Gate the synchronized inputs by input enable and hide the reserved pins.
    assign rdbk = sync_q & in_en_all & ~RSVD_PINS;

    // Select the read half for the addressed bank and register.
    always_comb begin
        rd_half = '0;
        case (reg_sel)
            REG_RDBK: rd_half = bank_sel ? rdbk[NPINS-1:BW] : rdbk[BW-1:0];
            REG_NONE: rd_half = '0;
            default:  rd_half = ctl_st[bank_sel][reg_sel];
        endcase
        bus_rdata = {{BW{1'b0}}, rd_half};
    end

endmodule

// File: rtl/gpio_setclr_chk.sv
// Property checker for gpio_setclr_top. It watches the bus, the pads and the
// bank register state, and is attached to every instance by bind.
module gpio_setclr_chk
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [NPINS-1:0] RSVD_PINS = 32'hE080_0000
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic [ADDR_W-1:0]                        bus_addr,
    input logic [NPINS-1:0]                         bus_wdata,
    input logic                                     bus_we,
    input logic [NPINS-1:0]                         bus_rdata,
    input logic [NPINS-1:0]                         pad_out,
    input logic [NPINS-1:0]                         pad_oe,
    input logic [1:0][NREG_CTL-1:0][NPINS/2-1:0]    ctl_st
);

    localparam int unsigned BW = NPINS / 2;
    localparam logic [ADDR_W-1:0] A_OUTVAL = '0;
    localparam logic [ADDR_W-1:0] A_RDBK   = ADDR_W'(8'h18);

    // The upper half of every read word is zero (R3).
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[NPINS-1:BW] == '0);

    // A set bit in a write to the low output-level register is stored (R2).
    assert_set_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OUTVAL && bus_wdata[0]) |=> ctl_st[0][REG_OUTVAL][0]);

    // A clear bit without a matching set clears the stored bit (R2).
    assert_clear_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OUTVAL && bus_wdata[BW] && !bus_wdata[0])
        |=> !ctl_st[0][REG_OUTVAL][0]);

    // Reserved pins never drive (R5).
    assert_rsvd_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RSVD_PINS) == '0);

    // An undriven pin presents a low output level (R6).
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // Without a write the pads stay as they are (R8).
    assert_pads_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_oe) && $stable(pad_out)));

    // Read-back of a pin with input disabled is zero (R7).
    assert_rdbk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RDBK && !ctl_st[0][REG_INEN][0]) |-> !bus_rdata[0]);

endmodule

bind gpio_setclr_top gpio_setclr_chk #(
    .NPINS     (NPINS),
    .ADDR_W    (ADDR_W),
    .RSVD_PINS (RSVD_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .ctl_st    (ctl_st)
);

// File: tb/gpio_setclr_top_test.sv
// Bench for gpio_setclr_top. A behavioural model is compared on every falling edge.
module gpio_setclr_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] RSVD = 32'hE080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Model state: six control registers over all 32 pins, plus the input history.
    logic [31:0] m_ctl [6];
    logic [31:0] m_s1 = '0;
    logic [31:0] m_s2 = '0;

    gpio_setclr_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected read word for an address, taken from the model.
    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v;
        int idx;
        idx = int'(a[4:2]);
        if (a[6:5] != 0 || a[1:0] != 0 || idx == 7) return 32'h0;
        if (idx == 6) v = m_s2 & m_ctl[2] & ~RSVD;
        else          v = m_ctl[idx];
        return a[7] ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
    endfunction

    // The model follows the same inputs as the design at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_ctl[i] = '0;
            m_s1 = '0;
            m_s2 = '0;
        end else begin
            if (bus_we && bus_addr[6:5] == 0 && bus_addr[1:0] == 0 && bus_addr[4:2] < 6) begin
                for (int p = 0; p < 16; p++) begin
                    int pin;
                    pin = bus_addr[7] ? p + 16 : p;
                    if (bus_wdata[p])           m_ctl[bus_addr[4:2]][pin] = 1'b1;
                    else if (bus_wdata[p + 16]) m_ctl[bus_addr[4:2]][pin] = 1'b0;
                end
                m_ctl[bus_addr[4:2]] = m_ctl[bus_addr[4:2]] & ~RSVD;
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare the pads and the read word with the model.
    task automatic cmp_all();
        logic [31:0] eoe;
        eoe = m_ctl[1] & ~m_ctl[3] & ~m_ctl[4];
        chk(pad_oe, eoe, "R6 drive enable");
        chk(pad_out, m_ctl[0] & eoe, "R6 drive level");
        chk(bus_rdata, m_read(bus_addr), "R1 R3 R7 read word");
    endtask

    // Advance one cycle: compare at the falling edge, before new inputs are driven.
    task automatic step();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_ctl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R4: after reset, nothing is driven and every register reads zero.
        chk(pad_oe, 32'h0, "R4 pads idle after reset");
        for (int i = 0; i < 7; i++) begin
            rd(8'(i * 4), 32'h0, "R4 low bank reset value");
            rd(8'(8'h80 + i * 4), 32'h0, "R4 high bank reset value");
        end

        // R6: drive low pins 0..3, output level 0101.
        wr(8'h04, 32'h0000_000F);
        wr(8'h00, 32'h0000_0005);
        step();
        chk(pad_oe & 32'hF, 32'hF, "R6 four pins driven");
        chk(pad_out & 32'hF, 32'h5, "R6 driven levels");

        // R2: set and clear of the same pin in one write, so the set wins.
        wr(8'h00, 32'h0002_0002);
        step();
        chk(pad_out & 32'hF, 32'h7, "R2 set wins over clear");
        wr(8'h00, 32'h0004_0000);
        step();
        chk(pad_out & 32'hF, 32'h3, "R2 clear only");

        // R6: alternate selects release the pad.
        wr(8'h0C, 32'h0000_0002);
        wr(8'h10, 32'h0000_0008);
        step();
        chk(pad_oe & 32'hF, 32'h5, "R6 alternate selects release pads");

        // R5 / R1: high bank at +0x80, reserved pins stay inert.
        wr(8'h84, 32'h0000_FFFF);
        wr(8'h80, 32'h0000_FFFF);
        step();
        chk(pad_oe[31:16], 16'h1F7F, "R5 reserved pins undriven");
        rd(8'h84, 32'h0000_1F7F, "R5 reserved bits read zero");

        // R1: off-grid and unused addresses are ignored.
        wr(8'h1C, 32'h0000_FFFF);
        wr(8'h02, 32'h0000_FFFF);
        wr(8'h24, 32'h0000_FFFF);
        step();
        rd(8'h1C, 32'h0, "R1 unused offset reads zero");
        rd(8'h08, 32'h0, "R1 stray writes left input enable alone");

        // R9: the input alternate select is stored without side effects.
        wr(8'h14, 32'h0000_00F0);
        step();
        rd(8'h14, 32'h0000_00F0, "R9 input alternate stored");
        chk(pad_oe & 32'hF, 32'h5, "R9 pads unaffected");

        // R7 / R8: two-edge input latency, gated by input enable.
        wr(8'h08, 32'h0000_0001);
        step(); step(); step();
        bus_addr = 8'h18;
        pad_in = 32'h0000_0003;
        @(negedge clk);
        rd(8'h18, 32'h0, "R8 not visible after one edge");
        @(negedge clk);
        rd(8'h18, 32'h1, "R8 visible after two edges, R7 pin 1 gated");
        wr(8'h18, 32'h0001_0000);
        step();
        rd(8'h18, 32'h1, "R7 read-back ignores writes");

        // Random traffic compared against the model on every cycle.
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            a = {$urandom_range(1, 0) == 1, 2'b00, 3'($urandom_range(6, 0)), 2'b00};
            if ($urandom_range(15, 0) == 0) a = 8'($urandom);
            pad_in = $urandom;
            if ($urandom_range(3, 0) != 0) wr(a, $urandom);
            else begin bus_addr = a; step(); end
        end

        // Final sweep of every address in both banks (R1, R3).
        for (int i = 0; i < 8; i++) begin
            bus_addr = 8'(i * 4);       step();
            bus_addr = 8'(8'h80 + i * 4); step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule